// File: doc/BRIEF.md
# Sample Averaging Filter

This block sits between a multiplexed 12-bit converter and a downstream threshold comparator. It adds up a programmable number of conversion results for one channel, from 1 to 128 in powers of two, and turns the sum into a 16-bit average. The extra four bits hold the fractional resolution that averaging gains. The upper 12 bits of that average are also given separately, for a comparator that works at the converter's native width.

An external start pulse launches the first conversion of a run. The block then requests each follow-on conversion itself, one strobe per accepted sample, until the programmed count has been gathered. A run therefore takes N conversion cycles. Several channels can be enabled at once. Each start averages one channel completely, and when that run ends the block moves its channel pointer to the next enabled channel, wrapping around. The pointer is driven out so that the converter's input multiplexer can follow it.

A start that arrives during a run restarts the run from an empty sum. A change to the configuration during a run abandons it. In neither case is a result produced for the discarded samples.

Top module: `sample_avg_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `res_valid` and `conv_req` are 0, `res_data` and `res_upper` are 0, and `conv_chan` is 0.
- R2: `cfg_avg_exp` holds an exponent k (0 to 7). Exactly one result is produced after N = 2^k accepted samples of a run.
- R3: The result is `res_data` = floor(S*16 / 2^k), where S is the sum of the N accepted 12-bit samples, truncated toward zero. `res_upper` equals `res_data[15:4]`.
- R4: `conv_req` pulses for one cycle, one clock after each accepted sample except the Nth. The start pulse itself causes no `conv_req`, so a run raises exactly N-1 of them.
- R5: `res_valid` is a one-cycle pulse, one clock after the Nth accepted sample.
- R6: A sample is accepted only while a run is active and `smp_chan` equals `conv_chan`. A sample on another channel, or one given while idle, changes neither the sum nor the count.
- R7: Bit i of `cfg_chan_en` enables channel i. A start selects the first enabled channel at or after the pointer and shows it on `conv_chan`. When a run completes, `res_chan` reports that channel and the pointer moves to the next enabled channel after it, wrapping.
- R8: A start during a run discards the partial sum and restarts counting from zero on the same channel. No result is produced for the discarded samples.
- R9: A change of `cfg_avg_exp` or `cfg_chan_en` during a run ends it. No result follows and no further `conv_req` is raised.
- R10: A start while no channel is enabled is ignored. No run begins, no `conv_req` is raised and no result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_avg_exp | input | 3 | Averaging exponent k, N = 2^k |
| cfg_chan_en | input | 8 | Per-channel enable mask, bit i for channel i |
| start | input | 1 | External start strobe, launches one run |
| smp_valid | input | 1 | Conversion result strobe |
| smp_chan | input | 3 | Channel the result belongs to |
| smp_data | input | 12 | Conversion result |
| conv_req | output | 1 | Internal request for the next conversion |
| conv_chan | output | 3 | Channel pointer for the input multiplexer |
| res_valid | output | 1 | Averaged result strobe |
| res_chan | output | 3 | Channel of the averaged result |
| res_data | output | 16 | Averaged result, 16 bits |
| res_upper | output | 12 | Upper 12 bits of the result, for the comparator |

## Verification
The block registers its outputs in a single stage. `conv_req`, or `res_valid` with its data and channel, is therefore due exactly one clock after the edge at which a sample is accepted, and `conv_chan` moves at the edge that takes a start or completes a run. The bench drives inputs on the falling edge. A behavioural model updates on the same rising edge as the design, and every output is compared at the next falling edge, so each result is checked in the very cycle it is due. Counts of results and requests over a whole run, and over an abandoned run, cover the cases that span many cycles.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // wrap an index into the range [0, n)
  function automatic int wrap_idx(input int v, input int n);
    return v % n;
  endfunction
endpackage

// File: rtl/sa_chan_pick.sv
module sa_chan_pick #(
  parameter int NCH  = 8,
  parameter int CW   = 3,
  parameter bit INCL = 1'b1
) (
  input  logic [NCH-1:0] en,
  input  logic [CW-1:0]  from,
  output logic           found,
  output logic [CW-1:0]  pick
);
  localparam int OFS = INCL ? 0 : 1;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NCH; i++) begin
      int idx;
      idx = sa_pkg::wrap_idx(int'(from) + i + OFS, NCH);
      if (!found && en[idx]) begin
        found = 1'b1;
        pick  = CW'(idx);
      end
    end
  end
endmodule

// File: rtl/sa_accum.sv
module sa_accum #(
  parameter int DW   = 12,
  parameter int AW   = 19,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            add,
  input  logic [DW-1:0]   din,
  output logic [AW-1:0]   acc,
  output logic [CNTW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (add) begin
      acc <= acc + AW'(din);
      cnt <= cnt + CNTW'(1);
    end
  end
endmodule

// File: rtl/sa_scale.sv
module sa_scale #(
  parameter int AW   = 19,
  parameter int OW   = 16,
  parameter int KW   = 3,
  parameter int FRAC = 4
) (
  input  logic [AW-1:0] sum,
  input  logic [KW-1:0] k,
  output logic [OW-1:0] res
);
  localparam int WW = AW + FRAC;
  logic [WW-1:0] wide;

  always_comb begin
    wide = WW'(sum) << FRAC;
    res  = OW'(wide >> k);
  end
endmodule

// File: rtl/sample_avg_top.sv
module sample_avg_top #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  parameter int KW  = 3,
  parameter int OW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [KW-1:0]          cfg_avg_exp,
  input  logic [NCH-1:0]         cfg_chan_en,
  input  logic                   start,
  input  logic                   smp_valid,
  input  logic [$clog2(NCH)-1:0] smp_chan,
  input  logic [DW-1:0]          smp_data,
  output logic                   conv_req,
  output logic [$clog2(NCH)-1:0] conv_chan,
  output logic                   res_valid,
  output logic [$clog2(NCH)-1:0] res_chan,
  output logic [OW-1:0]          res_data,
  output logic [DW-1:0]          res_upper
);
  localparam int CW   = $clog2(NCH);
  localparam int KMAX = (1 << KW) - 1;
  localparam int AW   = DW + KMAX;
  localparam int CNTW = KMAX + 1;
  localparam int FRAC = OW - DW;

  logic            busy;
  logic [CW-1:0]   ptr;
  logic [KW-1:0]   cap_exp;
  logic [NCH-1:0]  cap_en;
  logic [AW-1:0]   acc;
  logic [CNTW-1:0] cnt;
  logic [AW-1:0]   sum_nx;
  logic [OW-1:0]   scaled;
  logic            st_found, nx_found;
  logic [CW-1:0]   st_ch, nx_ch;
  logic            cfg_chg, accept, last;

  sa_chan_pick #(.NCH(NCH), .CW(CW), .INCL(1'b1)) u_pick_start (
    .en(cfg_chan_en), .from(ptr), .found(st_found), .pick(st_ch));

  sa_chan_pick #(.NCH(NCH), .CW(CW), .INCL(1'b0)) u_pick_next (
    .en(cap_en), .from(ptr), .found(nx_found), .pick(nx_ch));

  assign cfg_chg = busy && ((cfg_avg_exp != cap_exp) || (cfg_chan_en != cap_en));
  assign accept  = busy && !start && !cfg_chg && smp_valid && (smp_chan == ptr);
  assign last    = accept && ((cnt + CNTW'(1)) == (CNTW'(1) << cap_exp));
  assign sum_nx  = acc + AW'(smp_data);

  sa_accum #(.DW(DW), .AW(AW), .CNTW(CNTW)) u_accum (
    .clk(clk), .rst(rst), .clr(start), .add(accept),
    .din(smp_data), .acc(acc), .cnt(cnt));

  sa_scale #(.AW(AW), .OW(OW), .KW(KW), .FRAC(FRAC)) u_scale (
    .sum(sum_nx), .k(cap_exp), .res(scaled));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ptr       <= '0;
      cap_exp   <= '0;
      cap_en    <= '0;
      conv_req  <= 1'b0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
      res_upper <= '0;
    end else begin
      conv_req  <= 1'b0;
      res_valid <= 1'b0;
      if (start) begin
        if (st_found) begin
          busy    <= 1'b1;
          ptr     <= st_ch;
          cap_exp <= cfg_avg_exp;
          cap_en  <= cfg_chan_en;
        end else begin
          busy <= 1'b0;
        end
      end else if (cfg_chg) begin
        busy <= 1'b0;
      end else if (accept) begin
        if (last) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_chan  <= ptr;
          res_data  <= scaled;
          res_upper <= scaled[OW-1:FRAC];
          ptr       <= nx_found ? nx_ch : ptr;
        end else begin
          conv_req <= 1'b1;
        end
      end
    end
  end

  assign conv_chan = ptr;
endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           smp_valid,
  input logic           conv_req,
  input logic           res_valid,
  input logic [CW-1:0]  res_chan,
  input logic [NCH-1:0] cfg_chan_en
);
  logic [NCH-1:0] en_q;
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= cfg_chan_en;
  end

  // R5
  res_single_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R5
  res_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(smp_valid));

  // R4
  req_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> $past(smp_valid));

  // R4
  req_res_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(conv_req && res_valid));

  // R7
  res_chan_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> en_q[res_chan]);
endmodule

bind sample_avg_top sa_chk #(.NCH(NCH), .CW(CW)) u_sa_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .conv_req(conv_req),
  .res_valid(res_valid), .res_chan(res_chan), .cfg_chan_en(cfg_chan_en));

// File: tb/tb_sample_avg_top.sv
`timescale 1ns/1ps
module tb_sample_avg_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]  cfg_avg_exp = '0;
  logic [7:0]  cfg_chan_en = 8'h01;
  logic        start = 1'b0;
  logic        smp_valid = 1'b0;
  logic [2:0]  smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic        conv_req, res_valid;
  logic [2:0]  conv_chan, res_chan;
  logic [15:0] res_data;
  logic [11:0] res_upper;

  sample_avg_top dut (
    .clk(clk), .rst(rst), .cfg_avg_exp(cfg_avg_exp), .cfg_chan_en(cfg_chan_en),
    .start(start), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .conv_req(conv_req), .conv_chan(conv_chan), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .res_upper(res_upper));

  int checks = 0, fails = 0;
  int res_cnt = 0, req_cnt = 0;
  int last_res = 0, last_ch = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int first_en(input logic [7:0] en, input int from);
    for (int i = 0; i < 8; i++) if (en[(from + i) % 8]) return (from + i) % 8;
    return -1;
  endfunction

  // behavioural reference model, advanced on every rising edge
  bit m_busy = 0;
  int m_ptr = 0, m_exp = 0, m_sum = 0, m_cnt = 0, e_rd = 0, e_rc = 0;
  logic [7:0] m_en = '0;
  bit e_rv = 0, e_cr = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_ptr = 0; e_rv = 0; e_cr = 0; e_rd = 0; e_rc = 0;
    end else begin
      bit chg;
      int f;
      e_rv = 0; e_cr = 0;
      chg = m_busy && ((int'(cfg_avg_exp) != m_exp) || (cfg_chan_en != m_en));
      if (start) begin
        f = first_en(cfg_chan_en, m_ptr);
        if (f >= 0) begin
          m_busy = 1; m_ptr = f; m_exp = int'(cfg_avg_exp); m_en = cfg_chan_en;
          m_sum = 0; m_cnt = 0;
        end else m_busy = 0;
      end else if (chg) begin
        m_busy = 0;
      end else if (m_busy && smp_valid && int'(smp_chan) == m_ptr) begin
        m_sum += int'(smp_data);
        m_cnt++;
        if (m_cnt == (1 << m_exp)) begin
          m_busy = 0; e_rv = 1; e_rd = (m_sum * 16) >> m_exp; e_rc = m_ptr;
          m_ptr = first_en(m_en, (m_ptr + 1) % 8);
        end else e_cr = 1;
      end
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(res_valid == e_rv, "R5", "res_valid", res_valid, e_rv);
      chk(conv_req == e_cr, "R4", "conv_req", conv_req, e_cr);
      chk(int'(conv_chan) == m_ptr, "R7", "conv_chan", conv_chan, m_ptr);
      if (e_rv) begin
        chk(int'(res_data) == e_rd, "R3", "res_data", res_data, e_rd);
        chk(int'(res_upper) == (e_rd >> 4), "R3", "res_upper", res_upper, e_rd >> 4);
        chk(int'(res_chan) == e_rc, "R7", "res_chan", res_chan, e_rc);
      end
      if (res_valid) begin res_cnt++; last_res = int'(res_data); last_ch = int'(res_chan); end
      if (conv_req) req_cnt++;
    end
  end

  // converter stand-in: answers a start or a request two cycles later
  bit adc_on = 1, fixed_mode = 0, saw_start = 0;
  logic [11:0] fixed_val = '0;
  logic [15:0] lfsr = 16'hACE1;
  int dly = -1;
  always @(posedge clk) saw_start <= start;
  always @(negedge clk) begin
    if (adc_on) begin
      if (dly == 0) begin
        smp_valid = 1'b1; smp_chan = conv_chan;
        smp_data = fixed_mode ? fixed_val : lfsr[11:0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dly = -1;
      end else begin
        smp_valid = 1'b0;
        if (dly > 0) dly--;
      end
      if (saw_start || conv_req) dly = 2;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_one(input int k);
    int n0, t;
    cfg_avg_exp = 3'(k);
    n0 = res_cnt;
    pulse_start();
    t = 0;
    while (res_cnt == n0 && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic drive_sample(input int ch, input int val);
    @(negedge clk) begin smp_valid = 1'b1; smp_chan = 3'(ch); smp_data = 12'(val); end
    @(negedge clk) smp_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    int n0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(res_valid == 0 && conv_req == 0, "R1", "strobes in reset", {res_valid, conv_req}, 0);
    chk(res_data == 0 && res_upper == 0, "R1", "result in reset", res_data, 0);
    chk(conv_chan == 0, "R1", "pointer in reset", conv_chan, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 0 && conv_req == 0, "R1", "strobes after reset", {res_valid, conv_req}, 0);

    // R2 / R4: every averaging count on channel 0
    cfg_chan_en = 8'h01;
    for (int k = 0; k < 8; k++) begin
      n0 = res_cnt; r0 = req_cnt;
      run_one(k);
      chk(res_cnt == n0 + 1, "R2", $sformatf("results for k=%0d", k), res_cnt - n0, 1);
      chk(req_cnt - r0 == (1 << k) - 1, "R4", $sformatf("requests for k=%0d", k),
          req_cnt - r0, (1 << k) - 1);
    end

    // R3 boundaries
    fixed_mode = 1; fixed_val = 12'hFFF;
    run_one(7); chk(last_res == 65520, "R3", "full scale k=7", last_res, 65520);
    run_one(0); chk(last_res == 65520, "R3", "full scale k=0", last_res, 65520);
    fixed_val = 12'h000;
    run_one(3); chk(last_res == 0, "R3", "zero k=3", last_res, 0);
    fixed_val = 12'h001;
    run_one(2); chk(last_res == 16, "R3", "one lsb k=2", last_res, 16);
    fixed_mode = 0;

    // R7 sequencing over channels 2, 5, 7
    cfg_chan_en = 8'hA4;
    run_one(1); chk(last_ch == 2, "R7", "first channel", last_ch, 2);
    run_one(1); chk(last_ch == 5, "R7", "second channel", last_ch, 5);
    run_one(1); chk(last_ch == 7, "R7", "third channel", last_ch, 7);
    run_one(1); chk(last_ch == 2, "R7", "wrapped channel", last_ch, 2);

    // R8 restart during a run
    cfg_chan_en = 8'h08; cfg_avg_exp = 3'd4;
    n0 = res_cnt;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(res_cnt == n0, "R8", "no result before restart", res_cnt - n0, 0);
    run_one(4);
    chk(res_cnt == n0 + 1, "R8", "single result after restart", res_cnt - n0, 1);
    chk(last_ch == 3, "R8", "restart channel", last_ch, 3);

    // R9 configuration change during a run
    cfg_avg_exp = 3'd5;
    n0 = res_cnt;
    pulse_start();
    repeat (20) @(negedge clk);
    cfg_avg_exp = 3'd6;
    @(posedge clk); #1;
    r0 = req_cnt;
    repeat (400) @(negedge clk);
    chk(res_cnt == n0, "R9", "result after abandon", res_cnt - n0, 0);
    chk(req_cnt == r0, "R9", "requests after abandon", req_cnt - r0, 0);

    // R10 start with nothing enabled
    cfg_chan_en = 8'h00;
    n0 = res_cnt; r0 = req_cnt;
    pulse_start();
    repeat (50) @(negedge clk);
    chk(res_cnt == n0, "R10", "result with no channel", res_cnt - n0, 0);
    chk(req_cnt == r0, "R10", "request with no channel", req_cnt - r0, 0);

    // R6 foreign-channel and idle samples
    @(negedge clk) begin adc_on = 0; smp_valid = 1'b0; end
    cfg_chan_en = 8'h01; cfg_avg_exp = 3'd1;
    drive_sample(0, 100);
    r0 = req_cnt; n0 = res_cnt;
    pulse_start();
    drive_sample(3, 900);
    repeat (2) @(negedge clk);
    chk(req_cnt == r0, "R6", "request after foreign sample", req_cnt - r0, 0);
    drive_sample(0, 10);
    drive_sample(0, 30);
    repeat (3) @(negedge clk);
    chk(res_cnt == n0 + 1, "R6", "result count", res_cnt - n0, 1);
    chk(last_res == 320, "R6", "sum excludes ignored samples", last_res, 320);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule